// File: doc/BRIEF.md
# Program Counter Next-Address Sequencer

This block holds the program counter of a small microcontroller with 16-bit instructions and picks the next fetch address once per instruction cycle (one clock per instruction). The next value comes from one of several requests: a timer interrupt vector, a return, a call or jump target, a write to the low PC byte, a skip, or plain increment. Asynchronous reset forces the start address.

A 2-bit bank register sits above the 13-bit counter, and the two form the 15-bit ROM fetch address. Sequential flow never touches the bank. A bank write from the core loads it directly.

An 8-entry hardware return stack holds return addresses. Calls and taken interrupts push PC+1, and returns pop. Interrupt entry is refused while the stack is full, and the request is then dropped for that cycle. Instruction decode, the ALU and the timers live elsewhere and drive the request strobes.

Top module: `pc_sequencer`

## Requirements
- R1: `rom_addr_o` equals bank × 2^13 + PC: the bank occupies bits 14..13 and the PC occupies bits 12..0.
- R2: While `rst_ni` is low, the PC is 000H, the bank is 0 and the stack is empty, so `stack_full_o` is 0.
- R3: A Timer 0 request that is enabled loads PC with 008H when the stack is not full. The bank is kept and PC+1 is pushed.
- R4: A Timer 1 request that is enabled loads PC with 00CH under the same conditions as R3. When both timers are taken in the same cycle, Timer 0 wins.
- R5: A timer request whose enable is low, or that arrives while the stack is full, has no effect. The next lower request in the order of R12 takes effect instead.
- R6: With no request, the PC advances by 1 modulo 2^13 (1FFFH goes to 0000H) and the bank is unchanged.
- R7: A skip advances the PC by 2 modulo 2^13 (1FFFH goes to 0001H).
- R8: A low-byte write replaces PC bits 7..0 with `pcl_wdata_i` and keeps bits 12..8.
- R9: Jump and call load all 13 PC bits from `target_i`. A call pushes PC+1. When the stack is full, the call still jumps and the push is dropped.
- R10: A return loads the PC from the most recent stack entry and pops it. A return on an empty stack is ignored, and lower requests act.
- R11: The stack is last-in first-out with 8 entries. `stack_full_o` is high exactly when 8 entries are held.
- R12: Priority runs Timer 0 > Timer 1 > return > call > jump > low-byte write > skip > increment.
- R13: `bank_we_i` loads the bank from `bank_wdata_i` on the next edge, whatever PC source acts in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one instruction per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_t0_i | input | 1 | Timer 0 overflow request |
| irq_t0_en_i | input | 1 | Timer 0 interrupt enable |
| irq_t1_i | input | 1 | Timer 1 overflow request |
| irq_t1_en_i | input | 1 | Timer 1 interrupt enable |
| ret_i | input | 1 | Return request |
| call_i | input | 1 | Call request |
| jump_i | input | 1 | Jump request |
| target_i | input | 13 | Jump/call address field |
| pcl_we_i | input | 1 | Write to the low PC byte |
| pcl_wdata_i | input | 8 | Byte written to the low PC byte |
| skip_i | input | 1 | Skip request (PC+2) |
| bank_we_i | input | 1 | Bank pointer write |
| bank_wdata_i | input | 2 | New bank value |
| pc_o | output | 13 | Current program counter |
| bank_o | output | 2 | Current bank |
| rom_addr_o | output | 15 | ROM fetch address |
| stack_full_o | output | 1 | Return stack holds 8 entries |

## Verification
The collisions that matter most are an interrupt request arriving in the same cycle as a return, call, skip or low-byte write, and an interrupt arriving while the stack is full. The bench fills the stack with eight calls and then raises Timer 0 together with a skip. It expects the skip to act and `stack_full_o` to stay high. It also raises both timers together and expects the 008H vector. A long randomized sweep drives overlapping strobes in every combination. Each cycle is judged against an arithmetic model in the bench that applies the priority order of R12.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  typedef enum logic [2:0] {
    SRC_INC  = 3'd0,
    SRC_SKIP = 3'd1,
    SRC_PCL  = 3'd2,
    SRC_JMP  = 3'd3,
    SRC_CALL = 3'd4,
    SRC_RET  = 3'd5,
    SRC_IRQ1 = 3'd6,
    SRC_IRQ0 = 3'd7
  } pc_src_e;
endpackage

// File: rtl/pc_src_arb.sv
module pc_src_arb
  import pc_seq_pkg::*;
(
  input  logic    irq_t0_i,
  input  logic    irq_t0_en_i,
  input  logic    irq_t1_i,
  input  logic    irq_t1_en_i,
  input  logic    ret_i,
  input  logic    call_i,
  input  logic    jump_i,
  input  logic    pcl_we_i,
  input  logic    skip_i,
  input  logic    stk_full_i,
  input  logic    stk_empty_i,
  output pc_src_e src_o
);
  logic t0_take, t1_take, ret_take;

  // interrupts need a free stack slot; return needs an entry
  assign t0_take  = irq_t0_i & irq_t0_en_i & ~stk_full_i;
  assign t1_take  = irq_t1_i & irq_t1_en_i & ~stk_full_i;
  assign ret_take = ret_i & ~stk_empty_i;

  always_comb begin
    if (t0_take)       src_o = SRC_IRQ0;
    else if (t1_take)  src_o = SRC_IRQ1;
    else if (ret_take) src_o = SRC_RET;
    else if (call_i)   src_o = SRC_CALL;
    else if (jump_i)   src_o = SRC_JMP;
    else if (pcl_we_i) src_o = SRC_PCL;
    else if (skip_i)   src_o = SRC_SKIP;
    else               src_o = SRC_INC;
  end
endmodule

// File: rtl/pc_next_calc.sv
module pc_next_calc
  import pc_seq_pkg::*;
#(
  parameter int unsigned        PC_W   = 13,
  parameter int unsigned        PCL_W  = 8,
  parameter logic [PC_W-1:0]    VEC_T0 = 'h008,
  parameter logic [PC_W-1:0]    VEC_T1 = 'h00C
) (
  input  pc_src_e           src_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [PC_W-1:0]   stk_top_i,
  input  logic [PC_W-1:0]   target_i,
  input  logic [PCL_W-1:0]  pcl_wdata_i,
  input  logic              stk_full_i,
  output logic [PC_W-1:0]   pc_next_o,
  output logic [PC_W-1:0]   ret_addr_o,
  output logic              push_o,
  output logic              pop_o
);
  localparam int unsigned HI_W = PC_W - PCL_W;

  logic [PC_W-1:0] pc_inc1, pc_inc2;

  assign pc_inc1    = pc_i + PC_W'(1);
  assign pc_inc2    = pc_i + PC_W'(2);
  assign ret_addr_o = pc_inc1;

  always_comb begin
    pc_next_o = pc_inc1;
    push_o    = 1'b0;
    pop_o     = 1'b0;
    unique case (src_i)
      SRC_IRQ0: begin pc_next_o = VEC_T0; push_o = 1'b1; end
      SRC_IRQ1: begin pc_next_o = VEC_T1; push_o = 1'b1; end
      SRC_RET:  begin pc_next_o = stk_top_i; pop_o = 1'b1; end
      SRC_CALL: begin pc_next_o = target_i; push_o = ~stk_full_i; end
      SRC_JMP:  pc_next_o = target_i;
      SRC_PCL:  pc_next_o = {pc_i[PC_W-1 -: HI_W], pcl_wdata_i};
      SRC_SKIP: pc_next_o = pc_inc2;
      default:  pc_next_o = pc_inc1;
    endcase
  end
endmodule

// File: rtl/pc_ret_stack.sv
module pc_ret_stack #(
  parameter int unsigned W     = 13,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] top_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] wr_idx, top_idx;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign wr_idx  = IW'(cnt_q);
  assign top_idx = IW'(cnt_q - CW'(1));
  assign top_o   = mem[top_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (push_i && !full_o)      cnt_q <= cnt_q + CW'(1);
    else if (pop_i && !empty_o)      cnt_q <= cnt_q - CW'(1);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (push_i && !full_o && wr_idx == IW'(g)) mem[g] <= data_i;
    end
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pc_seq_pkg::*;
#(
  parameter int unsigned     PC_W      = 13,
  parameter int unsigned     BANK_W    = 2,
  parameter int unsigned     PCL_W     = 8,
  parameter int unsigned     STK_DEPTH = 8,
  parameter logic [PC_W-1:0] VEC_T0    = 'h008,
  parameter logic [PC_W-1:0] VEC_T1    = 'h00C,
  localparam int unsigned    ADDR_W    = PC_W + BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_t0_i,
  input  logic              irq_t0_en_i,
  input  logic              irq_t1_i,
  input  logic              irq_t1_en_i,
  input  logic              ret_i,
  input  logic              call_i,
  input  logic              jump_i,
  input  logic [PC_W-1:0]   target_i,
  input  logic              pcl_we_i,
  input  logic [PCL_W-1:0]  pcl_wdata_i,
  input  logic              skip_i,
  input  logic              bank_we_i,
  input  logic [BANK_W-1:0] bank_wdata_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ADDR_W-1:0] rom_addr_o,
  output logic              stack_full_o
);
  pc_src_e         src;
  logic [PC_W-1:0] pc_q, pc_next, stk_top, ret_addr;
  logic [BANK_W-1:0] bank_q;
  logic            push, pop, stk_full, stk_empty;

  pc_src_arb u_arb (
    .irq_t0_i    (irq_t0_i),
    .irq_t0_en_i (irq_t0_en_i),
    .irq_t1_i    (irq_t1_i),
    .irq_t1_en_i (irq_t1_en_i),
    .ret_i       (ret_i),
    .call_i      (call_i),
    .jump_i      (jump_i),
    .pcl_we_i    (pcl_we_i),
    .skip_i      (skip_i),
    .stk_full_i  (stk_full),
    .stk_empty_i (stk_empty),
    .src_o       (src)
  );

  pc_next_calc #(
    .PC_W   (PC_W),
    .PCL_W  (PCL_W),
    .VEC_T0 (VEC_T0),
    .VEC_T1 (VEC_T1)
  ) u_calc (
    .src_i       (src),
    .pc_i        (pc_q),
    .stk_top_i   (stk_top),
    .target_i    (target_i),
    .pcl_wdata_i (pcl_wdata_i),
    .stk_full_i  (stk_full),
    .pc_next_o   (pc_next),
    .ret_addr_o  (ret_addr),
    .push_o      (push),
    .pop_o       (pop)
  );

  pc_ret_stack #(
    .W     (PC_W),
    .DEPTH (STK_DEPTH)
  ) u_stack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (pop),
    .data_i  (ret_addr),
    .top_o   (stk_top),
    .full_o  (stk_full),
    .empty_o (stk_empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_next;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        bank_q <= '0;
    else if (bank_we_i) bank_q <= bank_wdata_i;
  end

  assign pc_o         = pc_q;
  assign bank_o       = bank_q;
  assign rom_addr_o   = {bank_q, pc_q};
  assign stack_full_o = stk_full;
endmodule

// File: rtl/pc_sequencer_sva.sv
module pc_sequencer_sva #(
  parameter int unsigned     PC_W   = 13,
  parameter int unsigned     BANK_W = 2,
  parameter int unsigned     PCL_W  = 8,
  parameter logic [PC_W-1:0] VEC_T0 = 'h008,
  parameter logic [PC_W-1:0] VEC_T1 = 'h00C
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_t0_i,
  input logic              irq_t0_en_i,
  input logic              irq_t1_i,
  input logic              irq_t1_en_i,
  input logic              ret_i,
  input logic              call_i,
  input logic              jump_i,
  input logic              pcl_we_i,
  input logic [PCL_W-1:0]  pcl_wdata_i,
  input logic              skip_i,
  input logic              bank_we_i,
  input logic [PC_W-1:0]   pc_o,
  input logic [BANK_W-1:0] bank_o,
  input logic              stack_full_o
);
  logic t0_go, t1_go, irq_go, lower_quiet;
  assign t0_go       = irq_t0_i && irq_t0_en_i && !stack_full_o;
  assign t1_go       = irq_t1_i && irq_t1_en_i && !stack_full_o;
  assign irq_go      = t0_go || t1_go;
  assign lower_quiet = !ret_i && !call_i && !jump_i;

  assert_t0_vector_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t0_go |=> pc_o == VEC_T0);

  assert_t1_vector_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!t0_go && t1_go) |=> pc_o == VEC_T1);

  assert_full_blocks_irq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stack_full_o && lower_quiet && !pcl_we_i && !skip_i)
      |=> pc_o == PC_W'($past(pc_o) + PC_W'(1)));

  assert_skip_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (skip_i && !irq_go && lower_quiet && !pcl_we_i)
      |=> pc_o == PC_W'($past(pc_o) + PC_W'(2)));

  assert_pcl_low_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pcl_we_i && !irq_go && lower_quiet)
      |=> (pc_o[PCL_W-1:0] == $past(pcl_wdata_i)) &&
          (pc_o[PC_W-1:PCL_W] == $past(pc_o[PC_W-1:PCL_W])));

  assert_full_holds_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stack_full_o && !ret_i) |=> stack_full_o);

  assert_bank_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bank_we_i |=> $stable(bank_o));
endmodule

bind pc_sequencer pc_sequencer_sva #(
  .PC_W   (PC_W),
  .BANK_W (BANK_W),
  .PCL_W  (PCL_W),
  .VEC_T0 (VEC_T0),
  .VEC_T1 (VEC_T1)
) u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .irq_t0_i     (irq_t0_i),
  .irq_t0_en_i  (irq_t0_en_i),
  .irq_t1_i     (irq_t1_i),
  .irq_t1_en_i  (irq_t1_en_i),
  .ret_i        (ret_i),
  .call_i       (call_i),
  .jump_i       (jump_i),
  .pcl_we_i     (pcl_we_i),
  .pcl_wdata_i  (pcl_wdata_i),
  .skip_i       (skip_i),
  .bank_we_i    (bank_we_i),
  .pc_o         (pc_o),
  .bank_o       (bank_o),
  .stack_full_o (stack_full_o)
);

// File: tb/pc_sequencer_tb.sv
`timescale 1ns/1ps
module pc_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        irq_t0_i = 0, irq_t0_en_i = 0, irq_t1_i = 0, irq_t1_en_i = 0;
  logic        ret_i = 0, call_i = 0, jump_i = 0, pcl_we_i = 0, skip_i = 0, bank_we_i = 0;
  logic [12:0] target_i = '0;
  logic [7:0]  pcl_wdata_i = '0;
  logic [1:0]  bank_wdata_i = '0;
  logic [12:0] pc_o;
  logic [1:0]  bank_o;
  logic [14:0] rom_addr_o;
  logic        stack_full_o;

  int n_tests = 0, n_fail = 0;
  logic [12:0] m_pc;
  logic [1:0]  m_bank;
  logic [12:0] m_stk [8];
  int          m_cnt;

  always #4 clk = ~clk;

  pc_sequencer u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .irq_t0_i(irq_t0_i), .irq_t0_en_i(irq_t0_en_i),
    .irq_t1_i(irq_t1_i), .irq_t1_en_i(irq_t1_en_i),
    .ret_i(ret_i), .call_i(call_i), .jump_i(jump_i), .target_i(target_i),
    .pcl_we_i(pcl_we_i), .pcl_wdata_i(pcl_wdata_i), .skip_i(skip_i),
    .bank_we_i(bank_we_i), .bank_wdata_i(bank_wdata_i),
    .pc_o(pc_o), .bank_o(bank_o), .rom_addr_o(rom_addr_o), .stack_full_o(stack_full_o)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk(tag, "pc", pc_o, m_pc);
    chk(tag, "bank", bank_o, m_bank);
    chk("R1", "rom_addr", rom_addr_o, {m_bank, m_pc});
    chk(tag, "full", stack_full_o, m_cnt == 8);
  endtask

  task automatic idle();
    {irq_t0_i, irq_t0_en_i, irq_t1_i, irq_t1_en_i} = '0;
    {ret_i, call_i, jump_i, pcl_we_i, skip_i, bank_we_i} = '0;
  endtask

  task automatic model_reset();
    m_pc = '0; m_bank = '0; m_cnt = 0;
  endtask

  // advance one cycle, update model from the driven inputs, compare
  task automatic step(string tag);
    logic [12:0] nxt;
    logic t0, t1;
    t0 = irq_t0_i && irq_t0_en_i && m_cnt < 8;
    t1 = irq_t1_i && irq_t1_en_i && m_cnt < 8;
    nxt = m_pc + 13'd1;
    if (t0) begin m_stk[m_cnt] = m_pc + 13'd1; m_cnt++; nxt = 13'h008; end
    else if (t1) begin m_stk[m_cnt] = m_pc + 13'd1; m_cnt++; nxt = 13'h00C; end
    else if (ret_i && m_cnt > 0) begin m_cnt--; nxt = m_stk[m_cnt]; end
    else if (call_i) begin
      if (m_cnt < 8) begin m_stk[m_cnt] = m_pc + 13'd1; m_cnt++; end
      nxt = target_i;
    end
    else if (jump_i) nxt = target_i;
    else if (pcl_we_i) nxt = {m_pc[12:8], pcl_wdata_i};
    else if (skip_i) nxt = m_pc + 13'd2;
    if (bank_we_i) m_bank = bank_wdata_i;
    @(posedge clk);
    #1;
    m_pc = nxt;
    chk_all(tag);
    idle();
  endtask

  initial begin
    #500000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    #10;
    chk_all("R2");
    @(negedge clk); rst_ni = 1'b1;
    #1;
    step("R6");

    // R8 low byte write keeps high bits
    jump_i = 1; target_i = 13'h1A55; step("R9");
    pcl_we_i = 1; pcl_wdata_i = 8'h3C; step("R8");
    // R6 / R7 wrap
    jump_i = 1; target_i = 13'h1FFF; step("R9");
    step("R6");
    jump_i = 1; target_i = 13'h1FFF; step("R9");
    skip_i = 1; step("R7");
    // R13 bank write alongside a jump, then sequential flow keeps bank
    bank_we_i = 1; bank_wdata_i = 2'd3; jump_i = 1; target_i = 13'h0100; step("R13");
    step("R6");
    // R3/R4 interrupts, both at once -> T0
    irq_t0_i = 1; irq_t0_en_i = 1; irq_t1_i = 1; irq_t1_en_i = 1; step("R4");
    ret_i = 1; step("R10");
    irq_t1_i = 1; irq_t1_en_i = 1; skip_i = 1; step("R4");
    ret_i = 1; step("R10");
    irq_t0_i = 1; irq_t0_en_i = 0; skip_i = 1; step("R5");
    irq_t0_i = 1; irq_t0_en_i = 1; step("R3");
    ret_i = 1; call_i = 1; target_i = 13'h0777; step("R12");
    // R10 return on empty stack is ignored
    ret_i = 1; jump_i = 1; target_i = 13'h0040; step("R10");
    ret_i = 1; step("R10");
    // R11 fill with eight calls
    for (int i = 0; i < 8; i++) begin
      call_i = 1; target_i = 13'(16 * i + 13'h0200); step("R11");
    end
    irq_t0_i = 1; irq_t0_en_i = 1; skip_i = 1; step("R5");
    irq_t1_i = 1; irq_t1_en_i = 1; step("R5");
    call_i = 1; target_i = 13'h0ABC; step("R9");
    for (int i = 0; i < 9; i++) begin
      ret_i = 1; step("R11");
    end

    // R12 randomized sweep with overlapping strobes
    for (int i = 0; i < 6000; i++) begin
      irq_t0_i = ($urandom % 6) == 0; irq_t0_en_i = ($urandom % 3) != 0;
      irq_t1_i = ($urandom % 6) == 0; irq_t1_en_i = ($urandom % 3) != 0;
      ret_i = ($urandom % 4) == 0;   call_i = ($urandom % 4) == 0;
      jump_i = ($urandom % 5) == 0;  pcl_we_i = ($urandom % 5) == 0;
      skip_i = ($urandom % 3) == 0;  bank_we_i = ($urandom % 7) == 0;
      target_i = 13'($urandom); pcl_wdata_i = 8'($urandom); bank_wdata_i = 2'($urandom);
      step("R12");
    end

    // R2 asynchronous reset mid-run
    #2; rst_ni = 1'b0; #1;
    model_reset();
    chk_all("R2");
    @(negedge clk); rst_ni = 1'b1; #1;
    step("R2");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule